// File: doc/BRIEF.md
# Multi-Source Interrupt Status Controller

This block collects the interrupt causes of a radio transceiver into one status word and one active-low request line. There are six causes: a power-on event, a FIFO service event, a FIFO overflow/underrun event, a wake-up timer strobe, an external level input and a low-supply level input. Each cause has its own status bit and its own rule for releasing that bit and its share of the request line. For some causes the status bit and the request contribution are released at different times.

A host polls `status_word` and pulses `stat_rd` for one cycle to mark that it has read it. The read returns the bits as they stood in that cycle. Any clear that the read triggers takes effect on the next clock edge. An event that arrives in the same cycle as a clearing read wins over the clear. The FIFO causes follow the direction set by `tx_mode`. In transmit direction they are released by switching the transmit path off. In receive direction the status is released by a read, and the request is released by draining a threshold number of bits or by disabling the receive path.

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the state resets. After reset `status_word` is 6'b000001, meaning only the power-on bit is set, and `irq_n` is 0. This assumes `ext_lvl` is low.
- R2: The power-on bit is `status_word[0]`. It is cleared on the clock edge that ends a cycle with `stat_rd` high, and it is never set again except by reset.
- R3: The wake-up bit is `status_word[3]`. It is set on the edge after a cycle with `wkup_evt` high. It is cleared on the edge after a cycle with `stat_rd` high, unless `wkup_evt` is also high in that cycle.
- R4: The external bit is `status_word[4]`. It equals `ext_lvl` combinationally, with no latching, and `irq_n` is low while `ext_lvl` is high.
- R5: The low-supply bit is `status_word[5]`. It shows the value `lowbat_lvl` had in the previous cycle. A rising level raises a request. A read releases that request, while bit 5 stays set for as long as `lowbat_lvl` is high.
- R6: `ovf_evt` sets both the FIFO bit `status_word[1]` and the overflow bit `status_word[2]`. `fifo_evt` sets only bit 1. Bit 2 is never set while bit 1 is clear. Either event raises the FIFO request.
- R7: With `tx_mode`=1, a read leaves bits 1 and 2 and the FIFO request unchanged. All three are cleared on the edge after a cycle with both `tx_en` and `tx_latch_en` low.
- R8: With `tx_mode`=0, a read clears bits 1 and 2 on the next edge. The FIFO request stays active until the sum of `fifo_rd_cnt` over the cycles since the last FIFO event reaches `FIFO_THRESH` (default 8). The request is released on the edge that ends the cycle in which that sum is reached.
- R9: With `tx_mode`=0, the FIFO request is released on the edge after a cycle with `rx_en` low or `rx_fifo_en` low.
- R10: `irq_n` is low exactly when at least one of these is active: the power-on bit, the wake-up bit, the FIFO request, `ext_lvl`, or the low-supply request.
- R11: During a read cycle `status_word` still shows the pre-clear value. A FIFO or wake-up event in the same cycle as a read or release condition keeps its bit and request set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_mode | input | 1 | 1 selects transmit-direction rules for the FIFO causes, 0 selects receive-direction rules |
| tx_en | input | 1 | Transmitter enabled |
| tx_latch_en | input | 1 | Transmit data latch enabled |
| rx_en | input | 1 | Receiver enabled |
| rx_fifo_en | input | 1 | Receive FIFO enabled |
| fifo_evt | input | 1 | FIFO service event strobe |
| ovf_evt | input | 1 | FIFO overflow/underrun strobe |
| wkup_evt | input | 1 | Wake-up timer strobe |
| ext_lvl | input | 1 | External interrupt level |
| lowbat_lvl | input | 1 | Supply-below-threshold level |
| fifo_rd_cnt | input | RD_W | Bits read from the receive FIFO in this cycle |
| stat_rd | input | 1 | Status word read strobe |
| status_word | output | 6 | Status bits {lowbat, ext, wkup, ovf, fifo, por} |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
A wrong state bit in this block shows at the ports on the first edge after the stimulus that should have moved it, because every status bit is wired straight to `status_word`. A mishandled request latch is hidden in one case: when the status bit and the request are released separately, the error is seen only through `irq_n`, and only once every other cause is quiet. The directed scenarios therefore release all other causes before they test the split release rules. A wrong FIFO drain counter shows as `irq_n` rising one fill step early or late around the threshold.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int STAT_W   = 6;
    localparam int B_POR    = 0;
    localparam int B_FIFO   = 1;
    localparam int B_OVF    = 2;
    localparam int B_WKUP   = 3;
    localparam int B_EXT    = 4;
    localparam int B_LOWBAT = 5;
    // read-cleared sticky sources, index into the generate array
    localparam int RC_N      = 3;
    localparam int RC_POR    = 0;
    localparam int RC_WKUP   = 1;
    localparam int RC_LB_REQ = 2;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/irq_sticky_src.sv
module irq_sticky_src #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // a new event beats a clear
        if (rst)   flag_d = RST_VAL;
    end

    always_ff @(posedge clk) begin
        flag_q <= flag_d;
    end

    assign q_o = flag_q;
endmodule

// File: rtl/irq_fifo_src.sv
module irq_fifo_src #(
    parameter int FIFO_THRESH = 8,
    parameter int RD_W        = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tx_mode,
    input  logic            tx_en,
    input  logic            tx_latch_en,
    input  logic            rx_en,
    input  logic            rx_fifo_en,
    input  logic            fifo_evt,
    input  logic            ovf_evt,
    input  logic            stat_rd,
    input  logic [RD_W-1:0] fifo_rd_cnt,
    output logic            fifo_stat_o,
    output logic            ovf_stat_o,
    output logic            req_o
);
    import irq_pkg::*;

    localparam int CNT_W = $clog2(FIFO_THRESH + 1);
    localparam int SUM_W = imax(CNT_W, RD_W) + 1;

    typedef struct packed {
        logic             fifo;
        logic             ovf;
        logic             req;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [SUM_W-1:0] drained;
    logic             tx_off, rx_off, evt;

    always_comb begin
        st_d    = st_q;
        evt     = fifo_evt | ovf_evt;
        tx_off  = !tx_en && !tx_latch_en;
        rx_off  = !rx_en || !rx_fifo_en;
        drained = SUM_W'(st_q.cnt) + SUM_W'(fifo_rd_cnt);

        if (tx_mode) begin
            // transmit direction: only switching the path off releases
            if (tx_off) begin
                st_d.fifo = 1'b0;
                st_d.ovf  = 1'b0;
                st_d.req  = 1'b0;
                st_d.cnt  = '0;
            end
        end else begin
            // receive direction: status by read, request by drain or disable
            if (stat_rd) begin
                st_d.fifo = 1'b0;
                st_d.ovf  = 1'b0;
            end
            if (rx_off) begin
                st_d.req = 1'b0;
                st_d.cnt = '0;
            end else if (st_q.req) begin
                if (drained >= SUM_W'(FIFO_THRESH)) begin
                    st_d.req = 1'b0;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = drained[CNT_W-1:0];
                end
            end
        end

        if (evt) begin
            st_d.fifo = 1'b1;
            st_d.req  = 1'b1;
            st_d.cnt  = '0;
            if (ovf_evt) st_d.ovf = 1'b1;
        end

        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fifo_stat_o = st_q.fifo;
    assign ovf_stat_o  = st_q.ovf;
    assign req_o       = st_q.req;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
    parameter int FIFO_THRESH = 8,
    parameter int RD_W        = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tx_mode,
    input  logic                       tx_en,
    input  logic                       tx_latch_en,
    input  logic                       rx_en,
    input  logic                       rx_fifo_en,
    input  logic                       fifo_evt,
    input  logic                       ovf_evt,
    input  logic                       wkup_evt,
    input  logic                       ext_lvl,
    input  logic                       lowbat_lvl,
    input  logic [RD_W-1:0]            fifo_rd_cnt,
    input  logic                       stat_rd,
    output logic [irq_pkg::STAT_W-1:0] status_word,
    output logic                       irq_n
);
    import irq_pkg::*;

    localparam logic [RC_N-1:0] RC_RST = RC_N'(1) << RC_POR;

    typedef struct packed {
        logic lb_lvl;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [RC_N-1:0] rc_set, rc_q;
    logic            lb_rise;
    logic            fifo_stat, ovf_stat, fifo_req;

    always_comb begin
        st_d        = st_q;
        st_d.lb_lvl = lowbat_lvl;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign lb_rise = lowbat_lvl && !st_q.lb_lvl;

    always_comb begin
        rc_set            = '0;
        rc_set[RC_WKUP]   = wkup_evt;
        rc_set[RC_LB_REQ] = lb_rise;
    end

    for (genvar g = 0; g < RC_N; g++) begin : g_rc
        irq_sticky_src #(.RST_VAL(RC_RST[g])) u_src (
            .clk  (clk),
            .rst  (rst),
            .set_i(rc_set[g]),
            .clr_i(stat_rd),
            .q_o  (rc_q[g])
        );
    end

    irq_fifo_src #(.FIFO_THRESH(FIFO_THRESH), .RD_W(RD_W)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .tx_mode    (tx_mode),
        .tx_en      (tx_en),
        .tx_latch_en(tx_latch_en),
        .rx_en      (rx_en),
        .rx_fifo_en (rx_fifo_en),
        .fifo_evt   (fifo_evt),
        .ovf_evt    (ovf_evt),
        .stat_rd    (stat_rd),
        .fifo_rd_cnt(fifo_rd_cnt),
        .fifo_stat_o(fifo_stat),
        .ovf_stat_o (ovf_stat),
        .req_o      (fifo_req)
    );

    always_comb begin
        status_word           = '0;
        status_word[B_POR]    = rc_q[RC_POR];
        status_word[B_FIFO]   = fifo_stat;
        status_word[B_OVF]    = ovf_stat;
        status_word[B_WKUP]   = rc_q[RC_WKUP];
        status_word[B_EXT]    = ext_lvl;
        status_word[B_LOWBAT] = st_q.lb_lvl;
    end

    assign irq_n = !((|rc_q) || fifo_req || ext_lvl);
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_mode,
    input logic       tx_en,
    input logic       fifo_evt,
    input logic       ovf_evt,
    input logic       wkup_evt,
    input logic       ext_lvl,
    input logic       lowbat_lvl,
    input logic       stat_rd,
    input logic [5:0] status_word,
    input logic       irq_n
);
    p_ovf_with_fifo_r6: assert property (@(posedge clk) disable iff (rst)
        status_word[2] |-> status_word[1]);

    p_por_cleared_r2: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> !status_word[0]);

    p_wkup_set_r3: assert property (@(posedge clk) disable iff (rst)
        wkup_evt |=> status_word[3]);

    p_wkup_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !wkup_evt) |=> !status_word[3]);

    p_ext_req_r4: assert property (@(posedge clk) disable iff (rst)
        ext_lvl |-> !irq_n);

    p_lowbat_level_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_word[5] == $past(lowbat_lvl)));

    p_tx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_mode && tx_en && status_word[2]) |=> status_word[2]);

    p_rx_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (!tx_mode && stat_rd && !fifo_evt && !ovf_evt) |=> !status_word[1]);

    p_irq_any_r10: assert property (@(posedge clk) disable iff (rst)
        (status_word[0] || status_word[3]) |-> !irq_n);
endmodule

bind irq_status_ctrl irq_status_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_mode    (tx_mode),
    .tx_en      (tx_en),
    .fifo_evt   (fifo_evt),
    .ovf_evt    (ovf_evt),
    .wkup_evt   (wkup_evt),
    .ext_lvl    (ext_lvl),
    .lowbat_lvl (lowbat_lvl),
    .stat_rd    (stat_rd),
    .status_word(status_word),
    .irq_n      (irq_n)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
    localparam int RD_W = 4;

    logic clk = 1'b0;
    logic rst, tx_mode, tx_en, tx_latch_en, rx_en, rx_fifo_en;
    logic fifo_evt, ovf_evt, wkup_evt, ext_lvl, lowbat_lvl, stat_rd;
    logic [RD_W-1:0] fifo_rd_cnt;
    logic [5:0] status_word;
    logic irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    irq_status_ctrl #(.FIFO_THRESH(8), .RD_W(RD_W)) dut (
        .clk(clk), .rst(rst), .tx_mode(tx_mode), .tx_en(tx_en),
        .tx_latch_en(tx_latch_en), .rx_en(rx_en), .rx_fifo_en(rx_fifo_en),
        .fifo_evt(fifo_evt), .ovf_evt(ovf_evt), .wkup_evt(wkup_evt),
        .ext_lvl(ext_lvl), .lowbat_lvl(lowbat_lvl), .fifo_rd_cnt(fifo_rd_cnt),
        .stat_rd(stat_rd), .status_word(status_word), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FIFO-free FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_strobes();
        fifo_evt = 0; ovf_evt = 0; wkup_evt = 0; stat_rd = 0; fifo_rd_cnt = '0;
    endtask

    task automatic t_reset();
        rst = 1; tx_mode = 0; tx_en = 0; tx_latch_en = 0; rx_en = 1; rx_fifo_en = 1;
        ext_lvl = 0; lowbat_lvl = 0; clear_strobes();
        step(); step();
        rst = 0;
        check("R1 reset status", 32'(status_word), 32'h01);
        check("R1 reset irq_n", 32'(irq_n), 32'h0);
    endtask

    task automatic t_por();
        stat_rd = 1;
        check("R11 por visible in read cycle", 32'(status_word[0]), 32'h1);
        step(); stat_rd = 0;
        check("R2 por cleared", 32'(status_word[0]), 32'h0);
        check("R10 idle irq_n high", 32'(irq_n), 32'h1);
    endtask

    task automatic t_wkup();
        wkup_evt = 1; step(); wkup_evt = 0;
        check("R3 wkup set", 32'(status_word[3]), 32'h1);
        check("R10 wkup irq", 32'(irq_n), 32'h0);
        stat_rd = 1; wkup_evt = 1; step(); stat_rd = 0; wkup_evt = 0;
        check("R11 event beats read", 32'(status_word[3]), 32'h1);
        stat_rd = 1; step(); stat_rd = 0;
        check("R3 wkup cleared", 32'(status_word[3]), 32'h0);
        check("R10 irq released", 32'(irq_n), 32'h1);
    endtask

    task automatic t_ext();
        ext_lvl = 1; #1;
        check("R4 ext bit follows", 32'(status_word[4]), 32'h1);
        check("R4 ext drives irq", 32'(irq_n), 32'h0);
        stat_rd = 1; step(); stat_rd = 0;
        check("R4 ext unaffected by read", 32'(status_word[4]), 32'h1);
        ext_lvl = 0; #1;
        check("R4 ext bit drops", 32'(status_word[4]), 32'h0);
        check("R4 irq released", 32'(irq_n), 32'h1);
    endtask

    task automatic t_lowbat();
        lowbat_lvl = 1; step();
        check("R5 lowbat bit set", 32'(status_word[5]), 32'h1);
        check("R5 lowbat request", 32'(irq_n), 32'h0);
        stat_rd = 1; step(); stat_rd = 0;
        check("R5 read releases request", 32'(irq_n), 32'h1);
        check("R5 bit held while low", 32'(status_word[5]), 32'h1);
        lowbat_lvl = 0; step();
        check("R5 bit follows level", 32'(status_word[5]), 32'h0);
    endtask

    task automatic t_tx();
        tx_mode = 1; tx_en = 1; tx_latch_en = 1;
        ovf_evt = 1; step(); ovf_evt = 0;
        check("R6 ovf sets both bits", 32'(status_word[2:1]), 32'h3);
        check("R6 fifo request", 32'(irq_n), 32'h0);
        stat_rd = 1; step(); stat_rd = 0;
        check("R7 read keeps tx bits", 32'(status_word[2:1]), 32'h3);
        tx_en = 0; step();
        check("R7 latch on holds", 32'(status_word[2:1]), 32'h3);
        tx_latch_en = 0; step();
        check("R7 tx off clears bits", 32'(status_word[2:1]), 32'h0);
        check("R7 tx off releases irq", 32'(irq_n), 32'h1);
        tx_en = 1; tx_latch_en = 1; fifo_evt = 1; step(); fifo_evt = 0;
        check("R6 fifo event alone", 32'(status_word[2:1]), 32'h1);
        tx_en = 0; tx_latch_en = 0; step();
        check("R7 cleanup", 32'(irq_n), 32'h1);
    endtask

    task automatic t_rx_drain();
        tx_mode = 0; rx_en = 1; rx_fifo_en = 1;
        ovf_evt = 1; step(); ovf_evt = 0;
        stat_rd = 1; step(); stat_rd = 0;
        check("R8 read clears rx bits", 32'(status_word[2:1]), 32'h0);
        check("R8 request held after read", 32'(irq_n), 32'h0);
        fifo_rd_cnt = 4; step();
        fifo_rd_cnt = 3; step();
        check("R8 below threshold holds", 32'(irq_n), 32'h0);
        fifo_rd_cnt = 1; step(); fifo_rd_cnt = 0;
        check("R8 threshold releases", 32'(irq_n), 32'h1);
        fifo_evt = 1; step(); fifo_evt = 0;
        fifo_rd_cnt = 7; step();
        fifo_rd_cnt = 2; fifo_evt = 1; step(); fifo_evt = 0; fifo_rd_cnt = 0;
        check("R11 event beats drain", 32'(irq_n), 32'h0);
        fifo_rd_cnt = 7; step(); fifo_rd_cnt = 0;
        check("R11 count restarted", 32'(irq_n), 32'h0);
        fifo_rd_cnt = 1; step(); fifo_rd_cnt = 0;
        check("R8 restarted drain releases", 32'(irq_n), 32'h1);
        stat_rd = 1; step(); stat_rd = 0;
    endtask

    task automatic t_rx_off();
        fifo_evt = 1; step(); fifo_evt = 0;
        rx_en = 0; step();
        check("R9 receiver off releases", 32'(irq_n), 32'h1);
        check("R9 status kept until read", 32'(status_word[1]), 32'h1);
        rx_en = 1; fifo_evt = 1; step(); fifo_evt = 0;
        check("R9 request back", 32'(irq_n), 32'h0);
        rx_fifo_en = 0; step(); rx_fifo_en = 1;
        check("R9 fifo off releases", 32'(irq_n), 32'h1);
        stat_rd = 1; step(); stat_rd = 0;
        check("R8 final clear", 32'(status_word), 32'h0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_por();
        t_wkup();
        t_ext();
        t_lowbat();
        t_tx();
        t_rx_drain();
        t_rx_off();
        finish_run();
    end
endmodule